// File: doc/BRIEF.md
# Caption Data Line Encoder

This block builds the level sequence for one caption or extended data service line in each video field. Software writes a pair of bytes for either field through a plain write port. The block counts lines from the field-start marker. When the count reaches the programmed target line, it waits a programmable number of clocks after that line's start pulse. It then plays out a run-in of seven bit-rate clock cycles, a three-bit start pattern and the two bytes. Each byte goes out as seven data bits, least significant first, followed by an odd parity bit that the block computes itself.

Bit cells are derived from the pixel clock by a fractional accumulator, so the bit rate stays locked at 32 times the line rate. A select input switches the line period between the 525-line value (1716 clocks) and the 625-line value (1728 clocks). The same encoding therefore serves 60 Hz and 50 Hz systems. The output is a one-bit level code per clock: 1 selects the roughly 50 IRE data level and 0 selects blank (0 IRE). A separate flag marks the active interval. The usual target is line 21, and the target line register can be moved within its width.

Top module: `cc_line_encoder`

## Requirements
- R1: While reset is held and after it is released, `cc_active` and `cc_level` are 0 until an insertion starts.
- R2: A line_start pulse sampled together with field_start makes that line number 1, and each later line_start adds one. Insertion starts only on the line whose number equals `cfg_line`.
- R3: When the edge that samples the target line's line_start is counted as edge 0, `cc_active` becomes 1 right after edge `cfg_delay`+1.
- R4: Counting clocks j from the first active cycle (j=0), half-cell h covers every j with floor(64*j/P)=h. P is 1716 when `sel_625`=0 and 1728 when `sel_625`=1. The line occupies 52 half-cells and then `cc_active` returns to 0.
- R5: Half-cells 0 to 13 alternate 1,0,1,0,… to form seven run-in cycles. After them each bit takes two half-cells, in this order: start bits 0,0,1, then the first byte's bits 0 to 6, its odd parity bit, then the second byte's bits 0 to 6 and its odd parity bit.
- R6: A write with `wr_field`=f stores `wr_byte_a` (first byte) and `wr_byte_b` (second byte) for field f. A field uses the pair of the `field_id` value latched at its field_start.
- R7: A field with no write since its last insertion sends the null pair 0x80, 0x80, which is all-zero data with parity bits 1. An insertion consumes the pending pair.
- R8: Outside the active interval `cc_level` is 0 (blank). Inside it, 1 means the 50 IRE level.
- R9: Bit 7 of a written byte has no effect. The parity bit is computed from bits 0 to 6 only.
- R10: A pending pair whose target line did not occur in a field is kept and sent in that field's next insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| field_start | input | 1 | Marks the line_start that opens a field |
| field_id | input | 1 | Field number, latched at field_start |
| sel_625 | input | 1 | 1 selects the 1728-clock line period, 0 selects the 1716-clock period |
| cfg_line | input | LINE_W | Target line number |
| cfg_delay | input | DLY_W | Clocks from line start to run-in |
| wr_en | input | 1 | Byte pair write strobe |
| wr_field | input | 1 | Field the written pair belongs to |
| wr_byte_a | input | 8 | First byte of the pair |
| wr_byte_b | input | 8 | Second byte of the pair |
| cc_active | output | 1 | High during the caption interval |
| cc_level | output | 1 | 1 selects the 50 IRE level, 0 selects blank |

## Verification
Whole-line waveforms are compared clock by clock against a closed-form model of half-cell boundaries. They are checked under both line periods. This separates an accumulator that drifts or uses the wrong step from one that is correctly locked to the line. Directed fields cover delays of 0 and 255, bytes whose parity differs and whose bit 7 is set, and interleaved writes for both fields. These cases separate bit ordering, parity and field selection faults. Fields with no write, and fields whose target line never arrives, show that the null pair is substituted and that a pending pair is kept. Random fields mix every one of these with random byte values.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } cc_state_e;

    localparam int RUNIN_HALVES = 14;
    localparam int FRAME_BITS   = 19;
    localparam int TOTAL_HALVES = RUNIN_HALVES + 2 * FRAME_BITS;
    localparam int HALF_W       = $clog2(TOTAL_HALVES);
    localparam int PERIOD_525   = 1716;
    localparam int PERIOD_625   = 1728;
    localparam int HALF_STEP    = 64;
    localparam logic [15:0] NULL_PAIR = 16'h8080;
endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
    parameter int ACC_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_625,
    output logic tick
);
    import cc_pkg::*;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] period;
    logic [ACC_W-1:0] sum;

    always_comb begin
        period = sel_625 ? ACC_W'(PERIOD_625) : ACC_W'(PERIOD_525);
        sum    = acc_q + ACC_W'(HALF_STEP);
        tick   = 1'b0;
        acc_d  = acc_q;
        if (!run) begin
            acc_d = '0;
        end else if (sum >= period) begin
            acc_d = sum - period;
            tick  = 1'b1;
        end else begin
            acc_d = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assert_acc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < period);

    assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (acc_q == '0));
endmodule

// File: rtl/cc_frame_builder.sv
module cc_frame_builder (
    input  logic [7:0]                     byte_a,
    input  logic [7:0]                     byte_b,
    output logic [cc_pkg::FRAME_BITS-1:0]  frame
);
    logic par_a, par_b;

    always_comb begin
        par_a = ~(^byte_a[6:0]);
        par_b = ~(^byte_b[6:0]);
        frame = {par_b, byte_b[6:0], par_a, byte_a[6:0], 3'b100};
    end
endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder
    import cc_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int DLY_W  = 8,
    parameter int ACC_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              field_start,
    input  logic              field_id,
    input  logic              sel_625,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              wr_en,
    input  logic              wr_field,
    input  logic [7:0]        wr_byte_a,
    input  logic [7:0]        wr_byte_b,
    output logic              cc_active,
    output logic              cc_level
);
    localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(TOTAL_HALVES - 1);
    localparam logic [HALF_W-1:0] RUNIN_H   = HALF_W'(RUNIN_HALVES);
    localparam int                IDX_W     = $clog2(FRAME_BITS);

    typedef struct packed {
        cc_state_e              state;
        logic [LINE_W-1:0]      line_cnt;
        logic                   field;
        logic [DLY_W-1:0]       dcnt;
        logic [HALF_W-1:0]      half;
        logic [FRAME_BITS-1:0]  frame;
        logic [1:0]             pend;
        logic [1:0][15:0]       pair;
    } enc_t;

    enc_t cur_q, nxt_d;

    logic                  tick;
    logic                  load_fld;
    logic [15:0]           sel_pair;
    logic [FRAME_BITS-1:0] frame_w;
    logic [LINE_W-1:0]     line_next;
    logic [HALF_W-1:0]     rel_half;
    logic [IDX_W-1:0]      bit_idx;

    cc_bit_timer #(.ACC_W(ACC_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cur_q.state == ST_SEND),
        .sel_625 (sel_625),
        .tick    (tick)
    );

    cc_frame_builder u_frame (
        .byte_a (sel_pair[7:0]),
        .byte_b (sel_pair[15:8]),
        .frame  (frame_w)
    );

    always_comb begin
        nxt_d     = cur_q;
        load_fld  = field_start ? field_id : cur_q.field;
        sel_pair  = cur_q.pend[load_fld] ? cur_q.pair[load_fld] : NULL_PAIR;
        line_next = field_start ? LINE_W'(1) : cur_q.line_cnt + LINE_W'(1);

        case (cur_q.state)
            ST_WAIT: begin
                if (cur_q.dcnt == cfg_delay) begin
                    nxt_d.state = ST_SEND;
                    nxt_d.half  = '0;
                end else begin
                    nxt_d.dcnt = cur_q.dcnt + DLY_W'(1);
                end
            end
            ST_SEND: begin
                if (tick) begin
                    if (cur_q.half == LAST_HALF) begin
                        nxt_d.state = ST_IDLE;
                        nxt_d.half  = '0;
                    end else begin
                        nxt_d.half = cur_q.half + HALF_W'(1);
                    end
                end
            end
            default: ;
        endcase

        if (line_start) begin
            nxt_d.line_cnt = line_next;
            if (field_start) nxt_d.field = field_id;
            if (line_next == cfg_line) begin
                nxt_d.state          = ST_WAIT;
                nxt_d.dcnt           = '0;
                nxt_d.half           = '0;
                nxt_d.frame          = frame_w;
                nxt_d.pend[load_fld] = 1'b0;
            end
        end

        if (wr_en) begin
            nxt_d.pair[wr_field] = {wr_byte_b, wr_byte_a};
            nxt_d.pend[wr_field] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        rel_half  = cur_q.half - RUNIN_H;
        bit_idx   = IDX_W'(rel_half >> 1);
        cc_active = (cur_q.state == ST_SEND);
        if (cur_q.state != ST_SEND)    cc_level = 1'b0;
        else if (cur_q.half < RUNIN_H) cc_level = ~cur_q.half[0];
        else                           cc_level = cur_q.frame[bit_idx];
    end

    assert_blank_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_active |-> !cc_level);

    assert_runin_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_active) |-> (cc_level && cur_q.half == '0));

    assert_line_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_active) |-> (cur_q.line_cnt == cfg_line));

    assert_half_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_active && $past(cc_active)) |->
            (cur_q.half == $past(cur_q.half) || cur_q.half == $past(cur_q.half) + HALF_W'(1)));

    assert_end_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cc_active) |-> ($past(cur_q.half) == LAST_HALF || $past(line_start)));
endmodule

// File: tb/cc_line_encoder_tb.sv
module cc_line_encoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       field_start = 1'b0;
    logic       field_id = 1'b0;
    logic       sel_625 = 1'b0;
    logic [8:0] cfg_line = 9'd21;
    logic [7:0] cfg_delay = 8'd0;
    logic       wr_en = 1'b0;
    logic       wr_field = 1'b0;
    logic [7:0] wr_byte_a = 8'd0;
    logic [7:0] wr_byte_b = 8'd0;
    logic       cc_active;
    logic       cc_level;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] m_pair [2];
    logic        m_pend [2];

    always #4 clk = ~clk;

    cc_line_encoder u_dut (
        .clk (clk), .rst_n (rst_n), .line_start (line_start),
        .field_start (field_start), .field_id (field_id), .sel_625 (sel_625),
        .cfg_line (cfg_line), .cfg_delay (cfg_delay), .wr_en (wr_en),
        .wr_field (wr_field), .wr_byte_a (wr_byte_a), .wr_byte_b (wr_byte_b),
        .cc_active (cc_active), .cc_level (cc_level)
    );

    function automatic logic exp_level(input int h, input logic [7:0] a, input logic [7:0] b);
        int i;
        if (h < 14) return (h % 2 == 0);
        i = (h - 14) / 2;
        if (i < 2)   return 1'b0;
        if (i == 2)  return 1'b1;
        if (i < 10)  return a[i-3];
        if (i == 10) return ~(^a[6:0]);
        if (i < 18)  return b[i-11];
        return ~(^b[6:0]);
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic f, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_field = f; wr_byte_a = a; wr_byte_b = b;
        @(negedge clk);
        wr_en = 1'b0;
        m_pair[f] = {b, a};
        m_pend[f] = 1'b1;
    endtask

    task automatic pulse_line(input logic fs, input logic fid);
        @(negedge clk);
        line_start = 1'b1; field_start = fs; field_id = fid;
        @(negedge clk);
        line_start = 1'b0; field_start = 1'b0;
    endtask

    // One line: k counts edges after the line_start edge; sampled at negedges.
    task automatic check_window(input int d, input logic sel, input logic [15:0] pr, input string req);
        int p, lim, bad_k, act, exp;
        bit bad;
        p = sel ? 1728 : 1716;
        lim = d + 1 + (52 * p + 63) / 64 + 4;
        bad = 0; bad_k = 0; act = 0; exp = 0;
        for (int k = 0; k <= lim; k++) begin
            int j, h;
            logic ea, el;
            j = k - (d + 1);
            h = (j >= 0) ? (64 * j) / p : -1;
            ea = (j >= 0) && (h < 52);
            el = ea ? exp_level(h, pr[7:0], pr[15:8]) : 1'b0;
            if (!bad && (cc_active !== ea || cc_level !== el)) begin
                bad = 1; bad_k = k;
                act = {cc_active, cc_level}; exp = {ea, el};
            end
            @(negedge clk);
        end
        check(!bad, req, $sformatf("line waveform at k=%0d {active,level}", bad_k), act, exp);
    endtask

    task automatic quiet_line(output bit bad);
        bad = 0;
        for (int k = 0; k < 12; k++) begin
            if (cc_active !== 1'b0 || cc_level !== 1'b0) bad = 1;
            @(negedge clk);
        end
    endtask

    task automatic run_field(input logic fid, input int t, input int nlines, input int d,
                             input logic sel, input string req);
        bit qbad, b1;
        logic [15:0] pr;
        qbad = 0;
        cfg_line = 9'(t); cfg_delay = 8'(d); sel_625 = sel;
        for (int n = 1; n <= nlines; n++) begin
            pulse_line(n == 1, fid);
            if (n == t) begin
                pr = m_pend[fid] ? m_pair[fid] : 16'h8080;
                m_pend[fid] = 1'b0;
                check_window(d, sel, pr, req);
            end else begin
                quiet_line(b1);
                if (b1) qbad = 1;
            end
        end
        check(!qbad, "R8", "output on non-target lines", qbad, 0);
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240531));
        m_pend[0] = 1'b0; m_pend[1] = 1'b0;
        m_pair[0] = 16'h8080; m_pair[1] = 16'h8080;
        repeat (3) @(negedge clk);
        check(cc_active === 1'b0 && cc_level === 1'b0, "R1", "outputs in reset", {cc_active, cc_level}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(cc_active === 1'b0 && cc_level === 1'b0, "R1", "outputs after reset", {cc_active, cc_level}, 0);

        // Usual line 21, 525-line period
        do_write(1'b0, 8'h41, 8'h2C);
        run_field(1'b0, 21, 22, 40, 1'b0, "R5");
        // 625-line period
        do_write(1'b0, 8'h13, 8'h6E);
        run_field(1'b0, 5, 6, 17, 1'b1, "R4");
        // Delay boundaries
        do_write(1'b1, 8'h55, 8'h2A);
        run_field(1'b1, 3, 4, 0, 1'b0, "R3");
        do_write(1'b1, 8'h7F, 8'h01);
        run_field(1'b1, 2, 3, 255, 1'b1, "R3");
        // Per-field pairs, played in reverse order of writes
        do_write(1'b0, 8'h31, 8'h32);
        do_write(1'b1, 8'h61, 8'h62);
        run_field(1'b1, 4, 5, 9, 1'b0, "R6");
        run_field(1'b0, 4, 5, 9, 1'b0, "R6");
        // Null pair when nothing written
        run_field(1'b0, 3, 4, 20, 1'b0, "R7");
        // Bit 7 ignored
        do_write(1'b1, 8'hC1, 8'hFE);
        run_field(1'b1, 2, 3, 12, 1'b1, "R9");
        // Target line not reached: pair kept
        do_write(1'b0, 8'h0F, 8'h70);
        run_field(1'b0, 9, 4, 12, 1'b0, "R2");
        run_field(1'b0, 3, 4, 30, 1'b0, "R10");

        // Random fields
        for (int r = 0; r < 10; r++) begin
            logic f, s;
            int nl, t, d;
            f  = 1'($urandom_range(0, 1));
            s  = 1'($urandom_range(0, 1));
            nl = $urandom_range(3, 7);
            t  = $urandom_range(2, nl + 1);
            d  = $urandom_range(0, 255);
            if ($urandom_range(0, 3) != 0)
                do_write(f, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
            run_field(f, t, nl, d, s, (t > nl) ? "R2" : "R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule